// File: doc/BRIEF.md
# Compound Point-Function Output Lock

This block guards one output bit of a combinational circuit behind a secret key. Two flip generators watch the primary input. The first is a single-point comparator that fires only when the compared input bits equal its key field. The second is a balanced AND tree over per-bit equality terms. Some of its gates in one chosen layer are replaced by XOR, so it fires on several input patterns per key. The two flips are ORed together.

The same OR is also formed against an embedded correct key, and this acts as a stripping term. The protected output is the original output XORed with the difference of the two ORs. A correct key therefore leaves the function untouched. A wrong key corrupts exactly those inputs where its flip set differs from the correct key's flip set.

The block is purely combinational. It sits between the original logic cone and the pin it protects. The key is one bus: the one-point field occupies the upper bits and the tree field the lower bits.

Top module: `cmpd_lock`

## Requirements
- R1: When `key_bus` equals the embedded correct key, `prot_out` equals `func_out` for every primary input.
- R2: The key bus is split by position. Bits `[KEY_W-1:MP_W]` are the one-point field and bits `[MP_W-1:0]` are the tree field.
- R3: The one-point generator fires exactly when `pi_data[OP_W-1:0]` equals the one-point field. `OP_W` may not exceed `IN_W`.
- R4: In the tree generator, each leaf is `pi_data[j]` XNOR key bit `j`. Nodes are paired layer by layer. In layer `REPL_LAYER`, the lowest `REPL_COUNT` nodes combine by XOR and all other nodes by AND. The root is the flip. With the defaults used in the checks (4 leaves, layer 0, one gate), the flip is `(e0^e1)&e2&e3`.
- R5: `prot_out = func_out ^ ((op(i,k)|mp(i,k)) ^ (op(i,k*)|mp(i,k*)))`, where `k*` is the embedded correct key.
- R6: Primary input bits at or above `max(OP_W, MP_W)` have no effect on `prot_out`.
- R7: When both generators fire on the same input, the output is inverted once, not twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pi_data | input | IN_W | Primary input of the protected cone |
| key_bus | input | OP_W+MP_W | Key: one-point field high, tree field low |
| func_out | input | 1 | Unprotected output of the original function |
| prot_out | output | 1 | Protected output |

## Verification
The one-point comparator and the tree can fire for the same input under the same wrong key. Whether the output flips once or cancels then depends entirely on the OR merge. This case is provoked by choosing a key whose one-point field equals an input that also satisfies the tree with a wrong tree field. The output must come out inverted. An exhaustive sweep of every key against every input at reduced widths also judges each overlap against an independently written model of the two flip sets.

// File: rtl/cmpd_lock_pkg.sv
package cmpd_lock_pkg;

  function automatic int cl_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit cl_is_pow2(input int v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

  // number of nodes in a given tree layer (layer 0 sits just above leaves)
  function automatic int cl_layer_nodes(input int leaves, input int layer);
    return leaves >> (layer + 1);
  endfunction

endpackage

// File: rtl/cl_point_match.sv
module cl_point_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] sel_bits,
  input  logic [W-1:0] ref_bits,
  output logic         hit
);
  assign hit = (sel_bits == ref_bits);
endmodule

// File: rtl/cl_multi_tree.sv
module cl_multi_tree
  import cmpd_lock_pkg::*;
#(
  parameter int W          = 4,
  parameter int REPL_LAYER = 0,
  parameter int REPL_COUNT = 1
) (
  input  logic [W-1:0] sel_bits,
  input  logic [W-1:0] ref_bits,
  output logic         hit
);
  localparam int LAYERS = $clog2(W);

  logic [W-1:0] lvl;
  logic [W-1:0] nxt;

  always_comb begin
    lvl = ~(sel_bits ^ ref_bits);
    nxt = '0;
    for (int l = 0; l < LAYERS; l++) begin
      nxt = '0;
      for (int g = 0; g < W / 2; g++) begin
        if (g < cl_layer_nodes(W, l)) begin
          if ((l == REPL_LAYER) && (g < REPL_COUNT))
            nxt[g] = lvl[2*g] ^ lvl[2*g+1];
          else
            nxt[g] = lvl[2*g] & lvl[2*g+1];
        end
      end
      lvl = nxt;
    end
    hit = lvl[0];
  end
endmodule

// File: rtl/cmpd_lock.sv
module cmpd_lock
  import cmpd_lock_pkg::*;
#(
  parameter int IN_W       = 13,
  parameter int OP_W       = 13,
  parameter int MP_W       = 4,
  parameter int REPL_LAYER = 0,
  parameter int REPL_COUNT = 1,
  parameter logic [OP_W-1:0] OP_KEY = 13'h1A5B,
  parameter logic [MP_W-1:0] MP_KEY = 4'h9
) (
  input  logic [IN_W-1:0]      pi_data,
  input  logic [OP_W+MP_W-1:0] key_bus,
  input  logic                 func_out,
  output logic                 prot_out
);
  localparam int KEY_W = OP_W + MP_W;
  localparam int CMP_W = cl_max(OP_W, MP_W);

  if (OP_W > IN_W) begin : g_bad_op
    $error("one-point key wider than primary input");
  end
  if (MP_W > IN_W || !cl_is_pow2(MP_W)) begin : g_bad_mp
    $error("tree key must be a power of two no wider than the input");
  end

  logic [OP_W-1:0] op_field;
  logic [MP_W-1:0] mp_field;
  logic            op_hit, mp_hit;   // generators driven by the applied key
  logic            op_ref, mp_ref;   // generators driven by the embedded key
  logic            flip_live, flip_ref, flip;

  assign op_field = key_bus[KEY_W-1:MP_W];
  assign mp_field = key_bus[MP_W-1:0];

  cl_point_match #(.W(OP_W)) u_op_live (
    .sel_bits(pi_data[OP_W-1:0]), .ref_bits(op_field), .hit(op_hit));
  cl_point_match #(.W(OP_W)) u_op_ref (
    .sel_bits(pi_data[OP_W-1:0]), .ref_bits(OP_KEY), .hit(op_ref));

  cl_multi_tree #(.W(MP_W), .REPL_LAYER(REPL_LAYER), .REPL_COUNT(REPL_COUNT)) u_mp_live (
    .sel_bits(pi_data[MP_W-1:0]), .ref_bits(mp_field), .hit(mp_hit));
  cl_multi_tree #(.W(MP_W), .REPL_LAYER(REPL_LAYER), .REPL_COUNT(REPL_COUNT)) u_mp_ref (
    .sel_bits(pi_data[MP_W-1:0]), .ref_bits(MP_KEY), .hit(mp_ref));

  assign flip_live = op_hit | mp_hit;
  assign flip_ref  = op_ref | mp_ref;
  assign flip      = flip_live ^ flip_ref;
  assign prot_out  = func_out ^ flip;

  if (IN_W > CMP_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^pi_data[IN_W-1:CMP_W];
  end
endmodule

// File: rtl/cmpd_lock_chk.sv
module cmpd_lock_chk #(
  parameter int IN_W = 13,
  parameter int OP_W = 13,
  parameter int MP_W = 4,
  parameter logic [OP_W-1:0] OP_KEY = '0,
  parameter logic [MP_W-1:0] MP_KEY = '0
) (
  input logic [IN_W-1:0]      pi_data,
  input logic [OP_W+MP_W-1:0] key_bus,
  input logic                 func_out,
  input logic                 prot_out,
  input logic                 op_hit,
  input logic                 mp_hit,
  input logic                 op_ref,
  input logic                 mp_ref
);
  localparam int KEY_W = OP_W + MP_W;

  always_comb begin
    if (key_bus == {OP_KEY, MP_KEY})
      a_r1_correct_key_clean: assert (prot_out == func_out);
    if (op_hit)
      a_r3_point_match: assert (pi_data[OP_W-1:0] == key_bus[KEY_W-1:MP_W]);
    if (key_bus[KEY_W-1:MP_W] == OP_KEY)
      a_r2_op_field_agree: assert (op_hit == op_ref);
    if (key_bus[MP_W-1:0] == MP_KEY)
      a_r4_tree_field_agree: assert (mp_hit == mp_ref);
    if (!op_hit && !mp_hit && !op_ref && !mp_ref)
      a_r5_quiet_passes: assert (prot_out == func_out);
    if (op_hit && mp_hit && !op_ref && !mp_ref)
      a_r7_double_fire_once: assert (prot_out != func_out);
  end
endmodule

bind cmpd_lock cmpd_lock_chk #(
  .IN_W(IN_W), .OP_W(OP_W), .MP_W(MP_W), .OP_KEY(OP_KEY), .MP_KEY(MP_KEY)
) u_chk (
  .pi_data(pi_data), .key_bus(key_bus), .func_out(func_out), .prot_out(prot_out),
  .op_hit(op_hit), .mp_hit(mp_hit), .op_ref(op_ref), .mp_ref(mp_ref)
);

// File: tb/test_cmpd_lock.sv
module test_cmpd_lock;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 6;
  localparam int OP_W = 5;
  localparam int MP_W = 4;
  localparam int KEY_W = OP_W + MP_W;
  localparam logic [OP_W-1:0] OPK = 5'h13;
  localparam logic [MP_W-1:0] MPK = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]  pi_data = '0;
  logic [KEY_W-1:0] key_bus = '0;
  logic             func_out = 1'b0;
  logic             prot_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  cmpd_lock #(
    .IN_W(IN_W), .OP_W(OP_W), .MP_W(MP_W), .REPL_LAYER(0), .REPL_COUNT(1),
    .OP_KEY(OPK), .MP_KEY(MPK)
  ) i_cmpd_lock (
    .pi_data(pi_data), .key_bus(key_bus), .func_out(func_out), .prot_out(prot_out)
  );

  // independent model: point compare and 4-leaf tree with its first pair XORed
  function automatic bit m_op(logic [IN_W-1:0] p, logic [OP_W-1:0] k);
    return p[OP_W-1:0] == k;
  endfunction
  function automatic bit m_mp(logic [IN_W-1:0] p, logic [MP_W-1:0] k);
    logic [3:0] e;
    e = ~(p[3:0] ^ k);
    return (e[0] ^ e[1]) & e[2] & e[3];
  endfunction
  function automatic bit m_out(logic [IN_W-1:0] p, logic [KEY_W-1:0] k, bit f);
    bit live, refk;
    live = m_op(p, k[KEY_W-1:MP_W]) | m_mp(p, k[MP_W-1:0]);
    refk = m_op(p, OPK) | m_mp(p, MPK);
    return f ^ live ^ refk;
  endfunction

  task automatic apply(input logic [IN_W-1:0] p, input logic [KEY_W-1:0] k, input bit f);
    @(posedge clk);
    #1;
    pi_data = p; key_bus = k; func_out = f;
    #3;
  endtask

  task automatic check(input string req, input bit exp);
    checks++;
    if (prot_out !== exp) begin
      errors++;
      $display("FAIL %s pi=%h key=%h f=%b got=%b exp=%b", req, pi_data, key_bus,
               func_out, prot_out, exp);
    end
  endtask

  task automatic t_reset_state;
    apply('0, {OPK, MPK}, 1'b0);
    check("R1", 1'b0);
    apply('0, {OPK, MPK}, 1'b1);
    check("R1", 1'b1);
  endtask

  task automatic t_r1_correct_key;
    for (int i = 0; i < 64; i++)
      for (int f = 0; f < 2; f++) begin
        apply(i[IN_W-1:0], {OPK, MPK}, f[0]);
        check("R1", f[0]);
      end
  endtask

  task automatic t_r3_point_only;
    // tree field correct; point field 04 fires only on low five bits 04
    apply(6'h04, {5'h04, MPK}, 1'b0);
    check("R3", 1'b1);
    apply(6'h05, {5'h04, MPK}, 1'b0);
    check("R3", 1'b0);
    apply(6'h1F, {5'h1F, MPK}, 1'b1);
    check("R3", 1'b0);
  endtask

  task automatic t_r4_tree_only;
    int bad = 0;
    // point field correct, tree field 5: wrong tree covers nibbles 4,7; correct 8,B
    for (int i = 0; i < 64; i++) begin
      apply(i[IN_W-1:0], {OPK, 4'h5}, 1'b0);
      if (prot_out) bad++;
    end
    checks++;
    if (bad != 16) begin
      errors++;
      $display("FAIL R4 corrupted-count got=%0d exp=16", bad);
    end
    apply(6'h07, {OPK, 4'h5}, 1'b0);
    check("R4", 1'b1);
    apply(6'h08, {OPK, 4'h5}, 1'b1);
    check("R4", 1'b0);
    apply(6'h06, {OPK, 4'h5}, 1'b1);
    check("R4", 1'b1);
  endtask

  task automatic t_r2_field_order;
    // swapping which field carries the point key must break correctness
    apply(6'h13, {5'h0A, 4'h3}, 1'b0);
    check("R2", m_out(6'h13, {5'h0A, 4'h3}, 1'b0));
    checks++;
    if (prot_out !== 1'b1) begin
      errors++;
      $display("FAIL R2 swapped fields got=%b exp=1", prot_out);
    end
  endtask

  task automatic t_r6_upper_ignored;
    bit a;
    for (int k = 0; k < 512; k += 37) begin
      apply(6'h04, k[KEY_W-1:0], 1'b0);
      a = prot_out;
      apply(6'h24, k[KEY_W-1:0], 1'b0);
      checks++;
      if (prot_out !== a) begin
        errors++;
        $display("FAIL R6 key=%h got=%b exp=%b", k, prot_out, a);
      end
    end
  endtask

  task automatic t_r7_double_fire;
    // point field 04 and tree field 5 both fire on input 04, reference does not
    apply(6'h04, {5'h04, 4'h5}, 1'b0);
    check("R7", 1'b1);
    apply(6'h04, {5'h04, 4'h5}, 1'b1);
    check("R7", 1'b0);
  endtask

  task automatic t_r5_sweep;
    for (int k = 0; k < 512; k++)
      for (int i = 0; i < 64; i++) begin
        apply(i[IN_W-1:0], k[KEY_W-1:0], i[0] ^ k[2]);
        check("R5", m_out(i[IN_W-1:0], k[KEY_W-1:0], i[0] ^ k[2]));
      end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_r1_correct_key();
    t_r3_point_only();
    t_r4_tree_only();
    t_r2_field_order();
    t_r6_upper_ignored();
    t_r7_double_fire();
    t_r5_sweep();
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule